// File: doc/BRIEF.md
# Interruption status save and restore unit

This unit keeps the processor status word of a simple in-order RISC front end and the saved copy that exists while an interruption is being handled. Each cycle it sees at most one instruction. It decides whether that instruction is suppressed, traps or commits. On a trap it saves the status word, clears the live word, and records the trapping instruction's address, its successor's address and its instruction word for the handler. A return strobe restores the live word from the saved copy. Software can write the saved copy.

The status word is 32 bits wide. Bit 10 is the nullify flag. Bits [1:0] hold the privilege level, where 0 is the most privileged level and 1 to 3 are user levels. Because a return restores exactly the bits the handler left in the saved copy, a handler that emulates a trapping instruction can set the saved nullify flag. The return then suppresses that instruction when it is fetched again. The address queue does not need to be rewritten.

Top module: `intr_state_unit`

## Requirements
- R1: While reset is held and in the cycle after it, the status word, saved status word, both address-queue entries and the instruction register read zero, and `intr_taken`, `intr_vector`, `ins_commit` and `ins_squashed` are zero.
- R2: When an instruction traps, the next cycle shows the saved status word equal to the status word held before the trap, and the status word is all zero.
- R3: A valid instruction presented while status bit 10 is 1 is suppressed. The next cycle shows `ins_squashed`=1 and `ins_commit`=0, no interruption is taken even for a privileged move, and bit 10 is 0.
- R4: A committed instruction with `ins_nullify_next`=1 sets status bit 10, and one with `ins_nullify_next`=0 leaves it 0. Cycles with no valid instruction leave bit 10 unchanged.
- R5: When `rfi_strobe`=1, the status word is loaded from the saved status word the next cycle, including any software changes. An instruction presented in the same cycle is ignored: it does not commit, trap or touch the queue.
- R6: The kind codes are 1 (space-register write), 2 (control-register write), 3 (control-register read) and 0 (any other instruction). An instruction of kind 1, 2 or 3 with privilege field bits [1:0] not 0 traps with vector 11. At privilege 0 the same instruction commits.
- R7: On an interruption, the front queue entry receives the instruction address, the back entry receives the following address, and the instruction register receives the instruction word. These three hold their values in all other cycles.
- R8: With `ext_trap_req`=1, an instruction that is not suppressed traps with vector `ext_trap_code`. When a privileged-register trap applies in the same cycle, vector 11 wins.
- R9: Results are registered and refer to the instruction of the previous cycle. `intr_taken` is a one-cycle pulse, `intr_vector` is zero when no pulse is present, and a trapping instruction never shows `ins_commit`.
- R10: A saved-status write becomes visible in the next cycle. When an interruption occurs in the same cycle, the hardware save wins over the write.
- R11: After a return whose restored bit 10 is 1, the first valid instruction is suppressed and the one after it commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_kind | input | 2 | 0 other, 1 space write, 2 control write, 3 control read |
| ins_addr | input | 32 | Address of the presented instruction |
| ins_next_addr | input | 32 | Address of its successor |
| ins_word | input | 32 | Instruction word |
| ins_nullify_next | input | 1 | The instruction asks to suppress its successor |
| ext_trap_req | input | 1 | Another trap condition for this instruction |
| ext_trap_code | input | 6 | Vector for that trap |
| rfi_strobe | input | 1 | Return from interruption |
| ipsw_wr_en | input | 1 | Software write of the saved status word |
| ipsw_wr_data | input | 32 | Data for that write |
| status_word | output | 32 | Live status word |
| saved_status | output | 32 | Saved status word |
| iaq_front | output | 32 | Address of the interrupted instruction |
| iaq_back | output | 32 | Address of its successor |
| iir_word | output | 32 | Interrupted instruction word |
| intr_taken | output | 1 | Interruption taken pulse |
| intr_vector | output | 6 | Trap vector with the pulse |
| ins_commit | output | 1 | Previous instruction committed |
| ins_squashed | output | 1 | Previous instruction was suppressed |

## Verification
A stale or wrongly set nullify bit appears at the ports one cycle later, as a suppression pulse where a commit was expected or the reverse. It appears directly on bit 10 of `status_word`. A save that drops or swaps bits appears in `saved_status` in the cycle right after the trap. If the corruption is confined to the saved copy, it reaches the live word one cycle after the next return. A queue that captures at the wrong time shows different entries after a return cycle or a suppressed cycle, even though no interruption was taken.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int WORD_W   = 32;
    localparam int VEC_W    = 6;
    localparam int NUL_POS  = 10;
    localparam int PRIV_W   = 2;
    localparam int PRIV_VEC = 11;

    typedef enum logic [1:0] {
        OP_PLAIN    = 2'd0,
        OP_SPACE_WR = 2'd1,
        OP_CTRL_WR  = 2'd2,
        OP_CTRL_RD  = 2'd3
    } op_kind_e;
endpackage

// File: rtl/isu_trap_check.sv
module isu_trap_check
    import isu_pkg::*;
#(
    parameter int PRIV_BITS = PRIV_W,
    parameter int VBITS     = VEC_W,
    parameter logic [VBITS-1:0] PRIV_CODE = VBITS'(PRIV_VEC)
) (
    input  op_kind_e             kind,
    input  logic [PRIV_BITS-1:0] priv,
    input  logic                 ext_req,
    input  logic [VBITS-1:0]     ext_code,
    output logic                 fire,
    output logic [VBITS-1:0]     code
);
    logic is_priv_move;
    logic user_mode;
    logic priv_hit;

    always_comb begin
        is_priv_move = (kind == OP_SPACE_WR) || (kind == OP_CTRL_WR) || (kind == OP_CTRL_RD);
        user_mode    = (priv != '0);
        priv_hit     = is_priv_move && user_mode;
        fire         = priv_hit || ext_req;
        if (priv_hit) begin
            code = PRIV_CODE;
        end else if (ext_req) begin
            code = ext_code;
        end else begin
            code = '0;
        end
    end
endmodule

// File: rtl/isu_status.sv
module isu_status #(
    parameter int W     = 32,
    parameter int N_BIT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_valid,
    input  logic         trap_fire,
    input  logic         nullify_next,
    input  logic         rfi,
    input  logic         sw_we,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] psw,
    output logic [W-1:0] ipsw,
    output logic         squash,
    output logic         commit,
    output logic         trap_take
);
    typedef struct packed {
        logic [W-1:0] psw;
        logic [W-1:0] ipsw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        squash    = exec_valid && st_q.psw[N_BIT];
        trap_take = exec_valid && !st_q.psw[N_BIT] && trap_fire;
        commit    = exec_valid && !st_q.psw[N_BIT] && !trap_fire;

        st_d = st_q;
        if (rfi) begin
            st_d.psw = st_q.ipsw;
        end else if (trap_take) begin
            st_d.ipsw = st_q.psw;
            st_d.psw  = '0;
        end else if (squash) begin
            st_d.psw[N_BIT] = 1'b0;
        end else if (commit) begin
            st_d.psw[N_BIT] = nullify_next;
        end
        if (sw_we && !trap_take) begin
            st_d.ipsw = sw_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psw  = st_q.psw;
    assign ipsw = st_q.ipsw;

    AST_SAVE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (ipsw == $past(psw)) && (psw == '0)); // R2
    AST_RFI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rfi |=> psw == $past(ipsw)); // R5
    AST_HW_SAVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && trap_take) |=> ipsw == $past(psw)); // R10
    AST_SQUASH_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !rfi) |=> !psw[N_BIT]); // R3
endmodule

// File: rtl/isu_addr_queue.sv
module isu_addr_queue #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] cur_addr,
    input  logic [W-1:0] nxt_addr,
    input  logic [W-1:0] word,
    output logic [W-1:0] front,
    output logic [W-1:0] back,
    output logic [W-1:0] iir
);
    localparam int ENTRIES = 3;

    logic [W-1:0] slot_d [ENTRIES];
    logic [W-1:0] slot_q [ENTRIES];
    logic [W-1:0] src    [ENTRIES];

    assign src[0] = cur_addr;
    assign src[1] = nxt_addr;
    assign src[2] = word;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_comb begin
            slot_d[g] = capture ? src[g] : slot_q[g];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    assign front = slot_q[0];
    assign back  = slot_q[1];
    assign iir   = slot_q[2];

    AST_QUEUE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (front == $past(cur_addr)) && (back == $past(nxt_addr)) && (iir == $past(word))); // R7
    AST_QUEUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(front) && $stable(back) && $stable(iir)); // R7
endmodule

// File: rtl/intr_state_unit.sv
module intr_state_unit
    import isu_pkg::*;
#(
    parameter int WW    = WORD_W,
    parameter int VW    = VEC_W,
    parameter int N_POS = NUL_POS,
    parameter int PW    = PRIV_W,
    parameter logic [VW-1:0] PRIV_CODE = VW'(PRIV_VEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic [1:0]    ins_kind,
    input  logic [WW-1:0] ins_addr,
    input  logic [WW-1:0] ins_next_addr,
    input  logic [WW-1:0] ins_word,
    input  logic          ins_nullify_next,
    input  logic          ext_trap_req,
    input  logic [VW-1:0] ext_trap_code,
    input  logic          rfi_strobe,
    input  logic          ipsw_wr_en,
    input  logic [WW-1:0] ipsw_wr_data,
    output logic [WW-1:0] status_word,
    output logic [WW-1:0] saved_status,
    output logic [WW-1:0] iaq_front,
    output logic [WW-1:0] iaq_back,
    output logic [WW-1:0] iir_word,
    output logic          intr_taken,
    output logic [VW-1:0] intr_vector,
    output logic          ins_commit,
    output logic          ins_squashed
);
    typedef struct packed {
        logic          commit;
        logic          squash;
        logic          taken;
        logic [VW-1:0] vec;
    } out_t;

    out_t out_d, out_q;

    logic          exec_valid;
    logic          fire;
    logic [VW-1:0] fire_code;
    logic          squash;
    logic          commit;
    logic          trap_take;

    assign exec_valid = ins_valid && !rfi_strobe;

    isu_trap_check #(.PRIV_BITS(PW), .VBITS(VW), .PRIV_CODE(PRIV_CODE)) u_chk (
        .kind     (op_kind_e'(ins_kind)),
        .priv     (status_word[PW-1:0]),
        .ext_req  (ext_trap_req),
        .ext_code (ext_trap_code),
        .fire     (fire),
        .code     (fire_code)
    );

    isu_status #(.W(WW), .N_BIT(N_POS)) u_st (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_valid   (exec_valid),
        .trap_fire    (fire),
        .nullify_next (ins_nullify_next),
        .rfi          (rfi_strobe),
        .sw_we        (ipsw_wr_en),
        .sw_wdata     (ipsw_wr_data),
        .psw          (status_word),
        .ipsw         (saved_status),
        .squash       (squash),
        .commit       (commit),
        .trap_take    (trap_take)
    );

    isu_addr_queue #(.W(WW)) u_aq (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (trap_take),
        .cur_addr (ins_addr),
        .nxt_addr (ins_next_addr),
        .word     (ins_word),
        .front    (iaq_front),
        .back     (iaq_back),
        .iir      (iir_word)
    );

    always_comb begin
        out_d.commit = commit;
        out_d.squash = squash;
        out_d.taken  = trap_take;
        out_d.vec    = trap_take ? fire_code : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ins_commit   = out_q.commit;
    assign ins_squashed = out_q.squash;
    assign intr_taken   = out_q.taken;
    assign intr_vector  = out_q.vec;

    AST_TRAP_NEVER_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        !(intr_taken && ins_commit)); // R9
    AST_PRIV_MOVE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && !status_word[N_POS] && (ins_kind != 2'd0) && (status_word[PW-1:0] != '0))
        |=> intr_taken && (intr_vector == PRIV_CODE)); // R6
    AST_SQUASH_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && status_word[N_POS]) |=> ins_squashed && !intr_taken && !ins_commit); // R3
    AST_RFI_IGNORES_INS: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_strobe |=> !ins_commit && !intr_taken && !ins_squashed); // R5
endmodule

// File: tb/sim_intr_state_unit.sv
`timescale 1ns/1ps
module sim_intr_state_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [1:0]  ins_kind = 2'd0;
    logic [31:0] ins_addr = '0;
    logic [31:0] ins_next_addr = '0;
    logic [31:0] ins_word = '0;
    logic        ins_nullify_next = 1'b0;
    logic        ext_trap_req = 1'b0;
    logic [5:0]  ext_trap_code = '0;
    logic        rfi_strobe = 1'b0;
    logic        ipsw_wr_en = 1'b0;
    logic [31:0] ipsw_wr_data = '0;
    logic [31:0] status_word, saved_status, iaq_front, iaq_back, iir_word;
    logic        intr_taken, ins_commit, ins_squashed;
    logic [5:0]  intr_vector;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    intr_state_unit u0 (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ins(input logic [1:0] k, input logic [31:0] a, input logic nn);
        ins_valid = 1'b1; ins_kind = k; ins_addr = a; ins_next_addr = a + 32'd4;
        ins_word = 32'hC0DE0000 | a; ins_nullify_next = nn;
    endtask

    task automatic idle();
        ins_valid = 1'b0; ins_kind = 2'd0; ins_nullify_next = 1'b0;
        ext_trap_req = 1'b0; ext_trap_code = '0; rfi_strobe = 1'b0; ipsw_wr_en = 1'b0;
    endtask

    // {valid, kind[2], nullify_next, ext_req, ext_code[6] | commit, squash, taken, vec[6], N}
    localparam logic [20:0] TBL [7] = '{
        {1'b1, 2'd0, 1'b0, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 6'd0,  1'b0},
        {1'b1, 2'd3, 1'b1, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 6'd0,  1'b1},
        {1'b1, 2'd0, 1'b1, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 6'd0,  1'b0},
        {1'b1, 2'd0, 1'b0, 1'b1, 6'd15, 1'b0, 1'b0, 1'b1, 6'd15, 1'b0},
        {1'b1, 2'd2, 1'b1, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 6'd0,  1'b1},
        {1'b0, 2'd0, 1'b0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 6'd0,  1'b1},
        {1'b1, 2'd0, 1'b0, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 6'd0,  1'b0}
    };

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc();
        chk("R1", "status in reset", status_word, 32'h0);
        cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1", "status", status_word, 32'h0);
        chk("R1", "saved", saved_status, 32'h0);
        chk("R1", "queue front", iaq_front, 32'h0);
        chk("R1", "queue back", iaq_back, 32'h0);
        chk("R1", "iir", iir_word, 32'h0);
        chk("R1", "pulses", {intr_taken, ins_commit, ins_squashed, intr_vector}, 32'h0);

        // table walk at privilege 0 (R3 R4 R6 R8 R9)
        for (int i = 0; i < 7; i++) begin
            logic v, nn, ex, ec, es, et, en;
            logic [1:0] k;
            logic [5:0] code, ev;
            {v, k, nn, ex, code, ec, es, et, ev, en} = TBL[i];
            idle();
            if (v) ins(k, 32'h1000 + 32'(i) * 32'd4, nn);
            ext_trap_req = ex; ext_trap_code = code;
            cyc();
            chk("R4", $sformatf("row%0d commit", i), 32'(ins_commit), 32'(ec));
            chk("R3", $sformatf("row%0d squash", i), 32'(ins_squashed), 32'(es));
            chk("R9", $sformatf("row%0d taken", i), 32'(intr_taken), 32'(et));
            chk("R8", $sformatf("row%0d vector", i), 32'(intr_vector), 32'(ev));
            chk("R4", $sformatf("row%0d nullify bit", i), 32'(status_word[10]), 32'(en));
            if (i == 3) begin
                chk("R7", "ext trap front", iaq_front, 32'h100C);
                chk("R7", "ext trap back", iaq_back, 32'h1010);
                chk("R2", "ext trap status cleared", status_word, 32'h0);
            end
        end
        idle();

        // software write of saved copy: privilege 3
        ipsw_wr_en = 1'b1; ipsw_wr_data = 32'h3;
        cyc();
        idle();
        chk("R10", "sw write visible", saved_status, 32'h3);

        // return with an instruction presented in the same cycle
        rfi_strobe = 1'b1; ins(2'd1, 32'h2000, 1'b0);
        cyc();
        idle();
        chk("R5", "restore", status_word, 32'h3);
        chk("R5", "ins ignored commit", 32'(ins_commit), 32'h0);
        chk("R5", "ins ignored taken", 32'(intr_taken), 32'h0);
        chk("R5", "queue untouched", iaq_front, 32'h100C);

        // privileged space write in user mode
        ins(2'd1, 32'h3000, 1'b0);
        cyc();
        idle();
        chk("R6", "priv trap taken", 32'(intr_taken), 32'h1);
        chk("R6", "priv vector", 32'(intr_vector), 32'd11);
        chk("R9", "no commit", 32'(ins_commit), 32'h0);
        chk("R2", "saved old status", saved_status, 32'h3);
        chk("R2", "status cleared", status_word, 32'h0);
        chk("R7", "front", iaq_front, 32'h3000);
        chk("R7", "back", iaq_back, 32'h3004);
        chk("R7", "iir", iir_word, 32'hC0DE3000);
        cyc();
        chk("R9", "pulse one cycle", 32'(intr_taken), 32'h0);
        chk("R9", "vector zero", 32'(intr_vector), 32'h0);

        // handler sets saved nullify and returns
        ipsw_wr_en = 1'b1; ipsw_wr_data = 32'h403;
        cyc();
        idle();
        rfi_strobe = 1'b1;
        cyc();
        idle();
        chk("R5", "restore with nullify", status_word, 32'h403);
        ins(2'd1, 32'h3000, 1'b0);
        cyc();
        idle();
        chk("R11", "refetched squashed", 32'(ins_squashed), 32'h1);
        chk("R3", "no trap while squashed", 32'(intr_taken), 32'h0);
        chk("R3", "nullify cleared", status_word, 32'h3);
        chk("R7", "queue held on squash", iaq_front, 32'h3000);
        ins(2'd0, 32'h3004, 1'b0);
        cyc();
        idle();
        chk("R11", "successor commits", 32'(ins_commit), 32'h1);

        // priv trap with ext request and sw write in same cycle
        ins(2'd2, 32'h3008, 1'b0);
        ext_trap_req = 1'b1; ext_trap_code = 6'd20;
        ipsw_wr_en = 1'b1; ipsw_wr_data = 32'hABC;
        cyc();
        idle();
        chk("R8", "priv wins over ext", 32'(intr_vector), 32'd11);
        chk("R10", "hw save wins", saved_status, 32'h3);

        // privilege 0 control read commits
        ins(2'd3, 32'h4000, 1'b0);
        cyc();
        idle();
        chk("R6", "priv0 commits", 32'(ins_commit), 32'h1);
        chk("R6", "priv0 no trap", 32'(intr_taken), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule